// File: doc/BRIEF.md
# Eight-Pin Configurable I/O Port with Edge Interrupts

This block is one general-purpose I/O port. Each pin has a direction bit and an option bit. Together they put the pin in one of four modes: floating input, input with pull-up and interrupt, open-drain output, or push-pull output. The port drives the pad output-enable, output value and pull-up enable. It samples the pad levels through a synchronizer and returns them on a small register bus. A falling edge on a pin that is allowed to interrupt sets a per-pin pending flag. The enabled pending flags raise an interrupt request and a wake request, both gated by the processor's global interrupt mask.

Two per-pin inputs from neighbouring logic can take over a pin. A peripheral can drive the pin through an alternate-function output, which is held off while the pin is an interrupt input. The ADC can claim the pin as an analog input, which forces it to float whatever the registers say. The wake request is purely combinational from the pending state, so it still reaches the clock controller while the system clock is stopped. No pin's drive depends on the power state, so entering a low-power mode leaves every pad unchanged.

Register offsets on the 2-bit address: 0 = output data (read: pin level), 1 = direction, 2 = option, 3 = pending flags (write 1 to clear). The mode of pin i is {direction[i], option[i]}.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the direction, option, data and pending registers read 0. Every pin is a floating input: pad_oe and pad_pu are 0, and irq and wake are low.
- R2: Mode 00 neither drives nor pulls the pad. Mode 01 sets pad_pu for that pin and leaves pad_oe at 0.
- R3: Mode 10 is open-drain. pad_do is 0, and pad_oe is 1 only while the pin's data bit is 0.
- R4: Mode 11 is push-pull. pad_oe is 1 and pad_do equals the pin's data bit.
- R5: A read of offset 0 returns the written data bit for pins whose direction bit is 1. For the other pins it returns the pad level, two clocks after the pad changes.
- R6: A falling edge on an interrupt-capable pin in mode 01 sets that pin's bit in the pending register at offset 3. Writing 1 to the bit clears it, and writing 0 leaves it.
- R7: Only pins marked in the IRQ_CAPABLE parameter (default pins 7 and 0) ever set a pending bit. Other pins in mode 01 give only a pull-up.
- R8: While irq_mask is 1, wake and irq stay low and the pending bits are kept. When irq_mask returns to 0, the requests appear again.
- R9: wake rises in the same cycle as the pending bit (three clocks after the pad falls), and irq follows one clock later.
- R10: A pin with analog_sel high has pad_oe = 0 and pad_pu = 0, and it sets no pending bit, whatever its mode.
- R11: With alt_en set, alt_out replaces the data bit. In mode 00 and mode 11 the pin drives alt_out push-pull, in mode 10 it drives it open-drain, and in mode 01 the alternate output is ignored.
- R12: A write to the direction or option register sets no pending bit, even when a synchronized falling edge arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data (combinational) |
| pad_in | input | NPINS | Pad input levels |
| pad_oe | output | NPINS | Pad output enable |
| pad_do | output | NPINS | Pad output value |
| pad_pu | output | NPINS | Pad pull-up enable |
| analog_sel | input | NPINS | Pin claimed as analog input |
| alt_en | input | NPINS | Alternate function owns pin output |
| alt_out | input | NPINS | Alternate function output value |
| irq_mask | input | 1 | Global interrupt mask, 1 = masked |
| irq | output | 1 | Registered interrupt request |
| wake | output | 1 | Combinational wake request |

## Verification
The hardest case to reach from the ports is the one in R12: a synchronized falling edge that lands in exactly the same clock as a configuration write. The stimulus drops the pad level at a falling clock edge. It waits one more cycle and then issues the option-register write, so that the write is sampled on the edge where the second synchronizer stage would first show the low level. It then reads the pending register. A second hard case is the R9 timing, where wake and irq are sampled cycle by cycle after a pad edge to confirm the one-clock gap between them.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [1:0] {
      MODE_FLOAT   = 2'b00,
      MODE_PULLIRQ = 2'b01,
      MODE_OPEN    = 2'b10,
      MODE_PUSH    = 2'b11
   } pin_mode_e;

   localparam logic [1:0] OFS_DATA = 2'd0;
   localparam logic [1:0] OFS_DIR  = 2'd1;
   localparam logic [1:0] OFS_OPT  = 2'd2;
   localparam logic [1:0] OFS_PEND = 2'd3;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
   import gpio_irq_pkg::*;
#(
   parameter int NPINS = 8
) (
   input  logic [NPINS-1:0] dir_q,
   input  logic [NPINS-1:0] opt_q,
   input  logic [NPINS-1:0] data_q,
   input  logic [NPINS-1:0] analog_sel,
   input  logic [NPINS-1:0] alt_en,
   input  logic [NPINS-1:0] alt_out,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_do,
   output logic [NPINS-1:0] pad_pu,
   output logic [NPINS-1:0] irq_arm
);
   for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
      pin_mode_e mode;
      logic      src, oe_b, do_b, pu_b, arm_b;

      assign mode = pin_mode_e'({dir_q[gi], opt_q[gi]});
      assign src  = alt_en[gi] ? alt_out[gi] : data_q[gi];

      always_comb begin
         oe_b  = 1'b0;
         do_b  = 1'b0;
         pu_b  = 1'b0;
         arm_b = 1'b0;
         if (!analog_sel[gi]) begin
            unique case (mode)
               MODE_FLOAT: begin
                  oe_b = alt_en[gi];
                  do_b = alt_en[gi] & alt_out[gi];
               end
               MODE_PULLIRQ: begin
                  pu_b  = 1'b1;
                  arm_b = 1'b1;
               end
               MODE_OPEN: begin
                  oe_b = ~src;
               end
               MODE_PUSH: begin
                  oe_b = 1'b1;
                  do_b = src;
               end
            endcase
         end
      end

      assign pad_oe[gi]  = oe_b;
      assign pad_do[gi]  = do_b;
      assign pad_pu[gi]  = pu_b;
      assign irq_arm[gi] = arm_b;
   end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int               NPINS       = 8,
   parameter logic [NPINS-1:0] IRQ_CAPABLE = 8'h81
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] lvl,
   input  logic [NPINS-1:0] arm,
   input  logic             rearm,
   input  logic             clr_wr,
   input  logic [NPINS-1:0] clr_bits,
   input  logic             irq_mask,
   output logic [NPINS-1:0] pend,
   output logic             wake,
   output logic             irq
);
   for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
      if (IRQ_CAPABLE[gi]) begin : g_cap
         logic prev_q, pend_q, fall;
         assign fall = prev_q & ~lvl[gi] & arm[gi] & ~rearm;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               prev_q <= lvl[gi];
               pend_q <= fall | (pend_q & ~(clr_wr & clr_bits[gi]));
            end
         end
         assign pend[gi] = pend_q;
      end else begin : g_plain
         logic unused_in;
         assign unused_in = ^{lvl[gi], arm[gi], clr_bits[gi]};
         assign pend[gi]  = 1'b0;
      end
   end

   assign wake = (|(pend & arm)) & ~irq_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= wake;
   end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int               NPINS       = 8,
   parameter logic [NPINS-1:0] IRQ_CAPABLE = 8'h81,
   parameter int               SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [NPINS-1:0] bus_wdata,
   output logic [NPINS-1:0] bus_rdata,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_do,
   output logic [NPINS-1:0] pad_pu,
   input  logic [NPINS-1:0] analog_sel,
   input  logic [NPINS-1:0] alt_en,
   input  logic [NPINS-1:0] alt_out,
   input  logic             irq_mask,
   output logic             irq,
   output logic             wake
);
   if (NPINS < 1 || NPINS > 32) begin : g_bad_width
      $error("gpio_irq_port: NPINS must be 1..32");
   end

   logic [NPINS-1:0] data_q, dir_q, opt_q, pin_lvl, irq_arm, pend;
   logic             wr_hit, cfg_wr, clr_wr;

   assign wr_hit = bus_sel & bus_wr;
   assign cfg_wr = wr_hit & ((bus_addr == OFS_DIR) | (bus_addr == OFS_OPT));
   assign clr_wr = wr_hit & (bus_addr == OFS_PEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         opt_q  <= '0;
      end else if (wr_hit) begin
         case (bus_addr)
            OFS_DATA: data_q <= bus_wdata;
            OFS_DIR:  dir_q  <= bus_wdata;
            OFS_OPT:  opt_q  <= bus_wdata;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (bus_addr)
         OFS_DATA: bus_rdata = (dir_q & data_q) | (~dir_q & pin_lvl);
         OFS_DIR:  bus_rdata = dir_q;
         OFS_OPT:  bus_rdata = opt_q;
         default:  bus_rdata = pend;
      endcase
   end

   gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_lvl)
   );

   gpio_pad_ctl #(.NPINS(NPINS)) u_pad (
      .dir_q(dir_q), .opt_q(opt_q), .data_q(data_q),
      .analog_sel(analog_sel), .alt_en(alt_en), .alt_out(alt_out),
      .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .irq_arm(irq_arm)
   );

   gpio_edge_irq #(.NPINS(NPINS), .IRQ_CAPABLE(IRQ_CAPABLE)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(pin_lvl), .arm(irq_arm),
      .rearm(cfg_wr), .clr_wr(clr_wr), .clr_bits(bus_wdata),
      .irq_mask(irq_mask), .pend(pend), .wake(wake), .irq(irq)
   );
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
   parameter int NPINS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] dir_q,
   input logic [NPINS-1:0] opt_q,
   input logic [NPINS-1:0] analog_sel,
   input logic [NPINS-1:0] pad_oe,
   input logic [NPINS-1:0] pad_do,
   input logic [NPINS-1:0] pad_pu,
   input logic [NPINS-1:0] pend,
   input logic             cfg_wr,
   input logic             irq_mask,
   input logic             irq,
   input logic             wake
);
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dir_q == '0 && opt_q == '0 && pend == '0 && !irq));

   p_pull_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);

   p_open_never_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q & ~opt_q & ~analog_sel & pad_oe & pad_do) == '0);

   p_mask_quiet_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask |-> !wake);

   p_mask_quiet_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask |=> !irq);

   p_analog_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (analog_sel & (pad_oe | pad_pu)) == '0);

   p_cfg_write_no_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> ((pend & ~$past(pend)) == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .opt_q(opt_q),
   .analog_sel(analog_sel), .pad_oe(pad_oe), .pad_do(pad_do),
   .pad_pu(pad_pu), .pend(pend), .cfg_wr(cfg_wr), .irq_mask(irq_mask),
   .irq(irq), .wake(wake)
);

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]   bus_addr = '0;
   logic [N-1:0] bus_wdata = '0, bus_rdata;
   logic [N-1:0] pad_in = '1, pad_oe, pad_do, pad_pu;
   logic [N-1:0] analog_sel = '0, alt_en = '0, alt_out = '0;
   logic         irq_mask = 1'b0, irq, wake;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_port #(.NPINS(N)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu),
      .analog_sel(analog_sel), .alt_en(alt_en), .alt_out(alt_out),
      .irq_mask(irq_mask), .irq(irq), .wake(wake)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [N-1:0] v;
      chk("R1 pad_oe", pad_oe, 0);
      chk("R1 pad_pu", pad_pu, 0);
      chk("R1 irq/wake", {irq, wake}, 0);
      rd(2'd1, v); chk("R1 dir", v, 0);
      rd(2'd2, v); chk("R1 opt", v, 0);
      rd(2'd3, v); chk("R1 pend", v, 0);
   endtask

   task automatic t_inputs;
      logic [N-1:0] v;
      wr(2'd2, 8'h0F);
      #1 chk("R2 pull-up in mode 01", pad_pu, 8'h0F);
      chk("R2 no drive in inputs", pad_oe, 0);
      pad_in = 8'hA5;
      idle(3);
      rd(2'd0, v); chk("R5 input level read", v, 8'hA5);
      pad_in = 8'hFF;
      wr(2'd2, 8'h00);
      idle(3);
   endtask

   task automatic t_outputs;
      logic [N-1:0] v;
      wr(2'd0, 8'h3C);
      wr(2'd2, 8'hF0);
      wr(2'd1, 8'hFF);
      #1 chk("R3/R4 pad_oe", pad_oe, 8'hF3);
      chk("R3/R4 pad_do", pad_do, 8'h30);
      pad_in = 8'h00;
      idle(3);
      rd(2'd0, v); chk("R5 output latch read", v, 8'h3C);
      pad_in = 8'hFF;
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h00);
      idle(3);
   endtask

   task automatic t_irq;
      logic [N-1:0] v;
      wr(2'd2, 8'hFF);
      idle(3);
      @(negedge clk); pad_in = 8'h00;
      idle(2);
      chk("R9 wake not yet", wake, 0);
      idle(1);
      chk("R9 wake with pending", wake, 1);
      chk("R9 irq one later", irq, 0);
      idle(1);
      chk("R9 irq asserted", irq, 1);
      rd(2'd3, v); chk("R6/R7 pending only capable pins", v, 8'h81);
      wr(2'd3, 8'h01);
      rd(2'd3, v); chk("R6 clear pin 0 only", v, 8'h80);
      chk("R6 wake held by pin 7", wake, 1);
      irq_mask = 1'b1;
      #1 chk("R8 wake masked", wake, 0);
      @(negedge clk); chk("R8 irq masked", irq, 0);
      rd(2'd3, v); chk("R8 pending kept", v, 8'h80);
      irq_mask = 1'b0;
      #1 chk("R8 wake returns", wake, 1);
      wr(2'd3, 8'h80);
      #1 chk("R6 wake after clear", wake, 0);
      @(negedge clk); chk("R6 irq after clear", irq, 0);
      pad_in = 8'hFF;
      idle(4);
   endtask

   task automatic t_rearm;
      logic [N-1:0] v;
      @(negedge clk); pad_in = 8'hFE;
      @(negedge clk);
      wr(2'd2, 8'hFF);
      idle(3);
      rd(2'd3, v); chk("R12 edge during cfg write ignored", v, 0);
      chk("R12 no wake", wake, 0);
      pad_in = 8'hFF;
      idle(4);
   endtask

   task automatic t_analog;
      logic [N-1:0] v;
      analog_sel = 8'h01;
      #1 chk("R10 analog no pull-up", pad_pu, 8'hFE);
      pad_in = 8'hFE;
      idle(5);
      rd(2'd3, v); chk("R10 analog no pending", v, 0);
      wr(2'd1, 8'hFF);
      #1 chk("R10 analog no drive", pad_oe, 8'hFE);
      analog_sel = 8'h00;
      wr(2'd1, 8'h00);
      pad_in = 8'hFF;
      idle(4);
      wr(2'd3, 8'hFF);
   endtask

   task automatic t_alt;
      wr(2'd0, 8'h80);
      wr(2'd2, 8'h81);
      wr(2'd1, 8'h84);
      alt_en = 8'h87; alt_out = 8'h03;
      #1 chk("R11 alt pad_oe", pad_oe, 8'h86);
      chk("R11 alt pad_do", pad_do, 8'h02);
      chk("R11 alt ignored in mode 01", pad_pu, 8'h01);
      alt_out = 8'h87;
      #1 chk("R11 alt pad_oe released", pad_oe, 8'h82);
      chk("R11 alt pad_do high", pad_do, 8'h82);
      alt_en = '0; alt_out = '0;
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_inputs();
      t_outputs();
      t_irq();
      t_rearm();
      t_analog();
      t_alt();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule